// File: doc/BRIEF.md
# Speculative Virtual-Channel Switch Allocator

This block is the allocation stage of a five-port virtual-channel router. The ports are East (0), West (1), North (2), South (3) and Local (4), and a 5x5 crossbar joins them. Each input port has three virtual channels. A flit at the front of each input virtual channel presents a request. For a head flit, the request also carries the route that was computed upstream. The downstream side reports which output virtual channels it can accept. Each cycle the block picks one virtual channel per input to bid. It then settles the crossbar for every output. Grants and crossbar selects are registered.

A head flit is speculative. It bids for a crossbar slot while an output virtual channel is being picked for it in the same cycle. If no output virtual channel is available, its switch grant is dropped and it must try again. Body and tail flits use the output port and output virtual channel that their head obtained, so they are non-speculative. When both kinds of flit compete for the same output, the non-speculative one always wins. An output virtual channel stays reserved from the head grant until the tail flit of that packet is granted.

Top module: `spec_vc_switch_alloc`

## Requirements
- R1: After reset, no grant and no crossbar enable is active, every output pointer starts at input 0, and every output virtual channel is unreserved.
- R2: A request presented in one cycle produces its grant at the next clock edge. For a lone head at input p, VC v, routed to output o (port code 0..4 = E, W, N, S, L; request index p*3+v), the next cycle shows gnt_valid_o[p]=1, gnt_ivc_o for p equal to v, xbar_en_o[o]=1 and xbar_sel_o for o equal to p.
- R3: A granted head receives the lowest-numbered output VC of its output that is both free downstream (ovc_free_i bit o*3+vc = 1) and not reserved by this block. That VC is reported on gnt_ovc_o.
- R4: If a head's output has no available output VC, the head gets no switch grant and no crossbar enable, and it leaves no state behind. The request must be presented again.
- R5: At an output, any non-speculative (body or tail) bid beats every speculative (head) bid, whatever the round-robin pointer says.
- R6: Within a class, each output arbitrates round-robin. The search starts at its pointer, and after a successful grant the pointer moves to the winner plus one, modulo 5.
- R7: Body and tail flits go to the output and output VC stored at the head grant. Their req_port_i value is ignored, and gnt_ovc_o shows the stored VC.
- R8: An output VC stays reserved from its head grant until the tail of that packet is granted. A flit that is both head and tail reserves nothing.
- R9: Each input bids with one VC. It picks the lowest-numbered non-speculative VC first, otherwise the lowest-numbered head. A body or tail request on a VC with no stored allocation is ignored.
- R10: Each input is granted at most one output, and each output carries at most one input per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 15 | Flit present, index p*3+v |
| req_head_i | input | 15 | Flit is a head |
| req_tail_i | input | 15 | Flit is a tail |
| req_port_i | input | 45 | Route of the head flit, 3 bits per request |
| ovc_free_i | input | 15 | Downstream VC can accept a packet, index o*3+vc |
| gnt_valid_o | output | 5 | Input p was granted |
| gnt_ivc_o | output | 10 | Granted input VC, 2 bits per input |
| gnt_ovc_o | output | 10 | Output VC used by the granted flit, 2 bits per input |
| xbar_en_o | output | 5 | Crossbar output o carries a flit |
| xbar_sel_o | output | 15 | Source input of output o, 3 bits per output |

## Verification
The hardest state to reach is an output whose three virtual channels are all reserved by unfinished packets while a fourth head is waiting. The bench gets there by granting three heads from different inputs to one output and holding back their tails. It then shows the fourth head being refused. Next it has a tail win against that waiting head, and finally the head is served with the freed VC. The priority case needs a round-robin pointer that favours the speculative input. The bench sets this up by letting the non-speculative input win first, which moves the pointer past it.

// File: rtl/spec_alloc_pkg.sv
package spec_alloc_pkg;

    // Circular search: first set bit of mask at or after start, -1 if none.
    function automatic int rr_pick(input logic [31:0] mask, input int start, input int n);
        int res;
        int idx;
        res = -1;
        for (int k = 0; k < n; k++) begin
            idx = (start + k) % n;
            if (res < 0 && mask[idx]) res = idx;
        end
        return res;
    endfunction

    // Lowest set bit of mask below n, -1 if none.
    function automatic int low_pick(input logic [31:0] mask, input int n);
        int res;
        res = -1;
        for (int k = n - 1; k >= 0; k--) begin
            if (mask[k]) res = k;
        end
        return res;
    endfunction

endpackage

// File: rtl/sa_input_sel.sv
module sa_input_sel #(
    parameter int NPORT = 5,
    parameter int NVC   = 3,
    localparam int PW   = $clog2(NPORT),
    localparam int VW   = (NVC > 1) ? $clog2(NVC) : 1
) (
    input  logic [NVC-1:0]    req_valid,
    input  logic [NVC-1:0]    req_head,
    input  logic [NVC-1:0]    req_tail,
    input  logic [NVC*PW-1:0] req_port,
    input  logic [NVC-1:0]    held,
    input  logic [NVC*PW-1:0] held_port,
    input  logic [NVC*VW-1:0] held_ovc,
    output logic              bid_valid,
    output logic              bid_spec,
    output logic              bid_tail,
    output logic [VW-1:0]     bid_vc,
    output logic [PW-1:0]     bid_port,
    output logic [VW-1:0]     bid_ovc
);
    import spec_alloc_pkg::*;

    logic [NVC-1:0] cont_m;
    logic [NVC-1:0] head_m;

    always_comb begin
        int ci;
        int hi;
        cont_m    = req_valid & ~req_head & held;
        head_m    = req_valid & req_head;
        ci        = low_pick(32'(cont_m), NVC);
        hi        = low_pick(32'(head_m), NVC);
        bid_valid = 1'b0;
        bid_spec  = 1'b0;
        bid_tail  = 1'b0;
        bid_vc    = '0;
        bid_port  = '0;
        bid_ovc   = '0;
        if (ci >= 0) begin
            bid_valid = 1'b1;
            bid_tail  = req_tail[ci];
            bid_vc    = VW'(ci);
            bid_port  = held_port[ci*PW +: PW];
            bid_ovc   = held_ovc[ci*VW +: VW];
        end else if (hi >= 0) begin
            bid_valid = 1'b1;
            bid_spec  = 1'b1;
            bid_tail  = req_tail[hi];
            bid_vc    = VW'(hi);
            bid_port  = req_port[hi*PW +: PW];
        end
    end

endmodule

// File: rtl/sa_output_arb.sv
module sa_output_arb #(
    parameter int NPORT  = 5,
    parameter int NVC    = 3,
    parameter int OUT_ID = 0,
    localparam int PW    = $clog2(NPORT),
    localparam int VW    = (NVC > 1) ? $clog2(NVC) : 1
) (
    input  logic [NPORT-1:0]    bid_valid,
    input  logic [NPORT-1:0]    bid_spec,
    input  logic [NPORT*PW-1:0] bid_port,
    input  logic [PW-1:0]       ptr,
    input  logic [NVC-1:0]      vc_avail,
    output logic                win_valid,
    output logic                win_spec,
    output logic [PW-1:0]       win_idx,
    output logic                ovc_found,
    output logic [VW-1:0]       ovc_idx,
    output logic                grant_ok,
    output logic                cont_present
);
    import spec_alloc_pkg::*;

    logic [NPORT-1:0] to_me;
    logic [NPORT-1:0] cont_m;
    logic [NPORT-1:0] spec_m;
    logic [NPORT-1:0] cls_m;

    // Switch side: class first, then round-robin inside the class.
    always_comb begin
        int w;
        for (int i = 0; i < NPORT; i++) begin
            to_me[i] = bid_valid[i] && (bid_port[i*PW +: PW] == PW'(OUT_ID));
        end
        cont_m       = to_me & ~bid_spec;
        spec_m       = to_me & bid_spec;
        cont_present = |cont_m;
        cls_m        = cont_present ? cont_m : spec_m;
        w            = rr_pick(32'(cls_m), int'(ptr), NPORT);
        win_valid    = (w >= 0);
        win_idx      = (w >= 0) ? PW'(w) : '0;
        win_spec     = (w >= 0) ? bid_spec[win_idx] : 1'b0;
    end

    // VC side, evaluated in parallel with the switch side.
    always_comb begin
        int v;
        v         = low_pick(32'(vc_avail), NVC);
        ovc_found = (v >= 0);
        ovc_idx   = (v >= 0) ? VW'(v) : '0;
    end

    assign grant_ok = win_valid && (!win_spec || ovc_found);

endmodule

// File: rtl/spec_vc_switch_alloc.sv
module spec_vc_switch_alloc #(
    parameter int NPORT = 5,
    parameter int NVC   = 3,
    localparam int PW   = $clog2(NPORT),
    localparam int VW   = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int NIVC = NPORT * NVC
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NIVC-1:0]     req_valid_i,
    input  logic [NIVC-1:0]     req_head_i,
    input  logic [NIVC-1:0]     req_tail_i,
    input  logic [NIVC*PW-1:0]  req_port_i,
    input  logic [NIVC-1:0]     ovc_free_i,
    output logic [NPORT-1:0]    gnt_valid_o,
    output logic [NPORT*VW-1:0] gnt_ivc_o,
    output logic [NPORT*VW-1:0] gnt_ovc_o,
    output logic [NPORT-1:0]    xbar_en_o,
    output logic [NPORT*PW-1:0] xbar_sel_o
);

    typedef struct packed {
        logic [NPORT-1:0][PW-1:0] ptr;
        logic [NIVC-1:0]          held;
        logic [NIVC-1:0][PW-1:0]  hport;
        logic [NIVC-1:0][VW-1:0]  hovc;
        logic [NPORT-1:0][NVC-1:0] busy;
        logic [NPORT-1:0]          gv;
        logic [NPORT-1:0][VW-1:0]  givc;
        logic [NPORT-1:0][VW-1:0]  govc;
        logic [NPORT-1:0]          xen;
        logic [NPORT-1:0][PW-1:0]  xsel;
    } alloc_state_t;

    alloc_state_t s_d, s_q;

    logic [NPORT-1:0]          bid_valid, bid_spec, bid_tail;
    logic [NPORT-1:0][VW-1:0]  bid_vc, bid_ovc;
    logic [NPORT*PW-1:0]       bid_port;
    logic [NPORT-1:0]          win_valid, win_spec, ovc_found, grant_ok, cont_present;
    logic [NPORT-1:0][PW-1:0]  win_idx;
    logic [NPORT-1:0][VW-1:0]  ovc_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_in
        sa_input_sel #(.NPORT(NPORT), .NVC(NVC)) u_sel (
            .req_valid (req_valid_i[p*NVC +: NVC]),
            .req_head  (req_head_i[p*NVC +: NVC]),
            .req_tail  (req_tail_i[p*NVC +: NVC]),
            .req_port  (req_port_i[p*NVC*PW +: NVC*PW]),
            .held      (s_q.held[p*NVC +: NVC]),
            .held_port (s_q.hport[p*NVC +: NVC]),
            .held_ovc  (s_q.hovc[p*NVC +: NVC]),
            .bid_valid (bid_valid[p]),
            .bid_spec  (bid_spec[p]),
            .bid_tail  (bid_tail[p]),
            .bid_vc    (bid_vc[p]),
            .bid_port  (bid_port[p*PW +: PW]),
            .bid_ovc   (bid_ovc[p])
        );
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        sa_output_arb #(.NPORT(NPORT), .NVC(NVC), .OUT_ID(o)) u_arb (
            .bid_valid    (bid_valid),
            .bid_spec     (bid_spec),
            .bid_port     (bid_port),
            .ptr          (s_q.ptr[o]),
            .vc_avail     (ovc_free_i[o*NVC +: NVC] & ~s_q.busy[o]),
            .win_valid    (win_valid[o]),
            .win_spec     (win_spec[o]),
            .win_idx      (win_idx[o]),
            .ovc_found    (ovc_found[o]),
            .ovc_idx      (ovc_idx[o]),
            .grant_ok     (grant_ok[o]),
            .cont_present (cont_present[o])
        );
    end

    always_comb begin
        int w;
        int iv;
        s_d      = s_q;
        s_d.gv   = '0;
        s_d.givc = '0;
        s_d.govc = '0;
        s_d.xen  = '0;
        s_d.xsel = '0;
        w        = 0;
        iv       = 0;
        for (int o = 0; o < NPORT; o++) begin
            if (grant_ok[o]) begin
                w            = int'(win_idx[o]);
                iv           = w * NVC + int'(bid_vc[w]);
                s_d.xen[o]   = 1'b1;
                s_d.xsel[o]  = win_idx[o];
                s_d.gv[w]    = 1'b1;
                s_d.givc[w]  = bid_vc[w];
                s_d.ptr[o]   = (w == NPORT - 1) ? '0 : PW'(w + 1);
                if (win_spec[o]) begin
                    s_d.govc[w] = ovc_idx[o];
                    if (!bid_tail[w]) begin
                        s_d.held[iv]             = 1'b1;
                        s_d.hport[iv]            = PW'(o);
                        s_d.hovc[iv]             = ovc_idx[o];
                        s_d.busy[o][ovc_idx[o]]  = 1'b1;
                    end
                end else begin
                    s_d.govc[w] = bid_ovc[w];
                    if (bid_tail[w]) begin
                        s_d.held[iv]             = 1'b0;
                        s_d.busy[o][bid_ovc[w]]  = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign gnt_valid_o = s_q.gv;
    assign gnt_ivc_o   = s_q.givc;
    assign gnt_ovc_o   = s_q.govc;
    assign xbar_en_o   = s_q.xen;
    assign xbar_sel_o  = s_q.xsel;

    // Crossbar/grant cross-relation views for the checks below.
    logic [NPORT-1:0][NPORT-1:0] hit_op;  // [output][input]
    logic [NPORT-1:0][NPORT-1:0] hit_po;  // [input][output]
    logic [NPORT-1:0]            src_granted;
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int p = 0; p < NPORT; p++) begin
                hit_op[o][p] = xbar_en_o[o] && (xbar_sel_o[o*PW +: PW] == PW'(p));
                hit_po[p][o] = hit_op[o][p];
            end
            src_granted[o] = |(hit_op[o] & gnt_valid_o);
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (gnt_valid_o == '0 && xbar_en_o == '0));

    for (genvar p = 0; p < NPORT; p++) begin : g_chk_in
        assert_grant_after_req_R2: assert property (@(posedge clk_i) disable iff (rst_i)
            gnt_valid_o[p] |-> $past(|req_valid_i[p*NVC +: NVC]));
        assert_one_output_per_input_R10: assert property (@(posedge clk_i) disable iff (rst_i)
            $countones(hit_po[p]) <= 1);
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_chk_out
        assert_xbar_source_granted_R10: assert property (@(posedge clk_i) disable iff (rst_i)
            xbar_en_o[o] |-> src_granted[o]);
        assert_nonspec_wins_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            cont_present[o] |-> (grant_ok[o] && !win_spec[o]));
        assert_spec_cancel_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            (win_valid[o] && win_spec[o] && !ovc_found[o]) |=> !xbar_en_o[o]);
    end

endmodule

// File: tb/test_spec_vc_switch_alloc.sv
module test_spec_vc_switch_alloc;
    localparam int NP = 5;
    localparam int NV = 3;
    localparam int PW = 3;
    localparam int VW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP*NV-1:0]    req_valid = '0, req_head = '0, req_tail = '0;
    logic [NP*NV*PW-1:0] req_port = '0;
    logic [NP*NV-1:0]    ovc_free = '1;
    logic [NP-1:0]       gv, xen;
    logic [NP*VW-1:0]    givc, govc;
    logic [NP*PW-1:0]    xsel;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    spec_vc_switch_alloc i_spec_vc_switch_alloc (
        .clk_i(clk), .rst_i(rst),
        .req_valid_i(req_valid), .req_head_i(req_head), .req_tail_i(req_tail),
        .req_port_i(req_port), .ovc_free_i(ovc_free),
        .gnt_valid_o(gv), .gnt_ivc_o(givc), .gnt_ovc_o(govc),
        .xbar_en_o(xen), .xbar_sel_o(xsel)
    );

    task automatic clr();
        req_valid = '0; req_head = '0; req_tail = '0; req_port = '0;
    endtask

    task automatic put(int p, int v, bit hd, bit tl, int port);
        req_valid[p*NV+v] = 1'b1;
        req_head[p*NV+v]  = hd;
        req_tail[p*NV+v]  = tl;
        req_port[(p*NV+v)*PW +: PW] = PW'(port);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_grant(string rq, int p, int ivc, int ovc, int o);
        total++;
        if (!(gv[p] && int'(givc[p*VW +: VW]) == ivc && int'(govc[p*VW +: VW]) == ovc &&
              xen[o] && int'(xsel[o*PW +: PW]) == p && $countones(gv) == 1 && $countones(xen) == 1)) begin
            bad++;
            $display("FAIL %s: gv=%b ivc=%0d ovc=%0d xen=%b sel=%0d ; expected in=%0d ivc=%0d ovc=%0d out=%0d",
                     rq, gv, givc[p*VW +: VW], govc[p*VW +: VW], xen, xsel[o*PW +: PW], p, ivc, ovc, o);
        end
    endtask

    task automatic expect_idle(string rq);
        total++;
        if (gv != '0 || xen != '0) begin
            bad++;
            $display("FAIL %s: gv=%b xen=%b ; expected gv=00000 xen=00000", rq, gv, xen);
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_idle("R1 reset state");

        // R2/R3/R7/R8 sweep: every input, output and input VC.
        for (int p = 0; p < NP; p++) begin
            for (int o = 0; o < NP; o++) begin
                for (int v = 0; v < NV; v++) begin
                    clr(); put(p, v, 1'b1, 1'b0, o); step();
                    expect_grant("R2 R3 head", p, v, 0, o);
                    clr(); put(p, v, 1'b0, 1'b1, (o + 1) % NP); step();
                    expect_grant("R7 R8 tail uses stored route", p, v, 0, o);
                end
            end
        end

        // R6: all pointers are back at 0; single-flit packets to South.
        clr(); put(1, 0, 1'b1, 1'b1, 3); put(2, 0, 1'b1, 1'b1, 3); put(3, 0, 1'b1, 1'b1, 3);
        step(); expect_grant("R6 rr first", 1, 0, 0, 3);
        step(); expect_grant("R6 rr second", 2, 0, 0, 3);
        step(); expect_grant("R6 rr third", 3, 0, 0, 3);
        step(); expect_grant("R6 rr wrap", 1, 0, 0, 3);

        // R8/R4/R5: fill all VCs of West.
        clr(); put(0, 0, 1'b1, 1'b0, 1); step(); expect_grant("R3 vc0", 0, 0, 0, 1);
        clr(); put(2, 0, 1'b1, 1'b0, 1); step(); expect_grant("R3 R8 vc1", 2, 0, 1, 1);
        clr(); put(3, 0, 1'b1, 1'b0, 1); step(); expect_grant("R3 R8 vc2", 3, 0, 2, 1);
        clr(); put(4, 0, 1'b1, 1'b0, 1); step(); expect_idle("R4 R8 no vc left");
        clr(); put(4, 0, 1'b1, 1'b0, 1); put(0, 0, 1'b0, 1'b1, 1); step();
        expect_grant("R5 tail beats head", 0, 0, 0, 1);
        clr(); put(4, 0, 1'b1, 1'b0, 1); step(); expect_grant("R4 R8 retry gets freed vc", 4, 0, 0, 1);
        clr(); put(2, 0, 1'b0, 1'b1, 1); step(); expect_grant("R7 tail vc1", 2, 0, 1, 1);
        clr(); put(3, 0, 1'b0, 1'b1, 1); step(); expect_grant("R7 tail vc2", 3, 0, 2, 1);
        clr(); put(4, 0, 1'b0, 1'b1, 1); step(); expect_grant("R7 tail vc0", 4, 0, 0, 1);

        // R3/R4 with downstream-free mask on East.
        ovc_free[2:0] = 3'b000;
        clr(); put(1, 1, 1'b1, 1'b0, 0); step(); expect_idle("R4 downstream full");
        ovc_free[2:0] = 3'b110;
        clr(); put(1, 1, 1'b1, 1'b0, 0); step(); expect_grant("R3 skips not-free vc0", 1, 1, 1, 0);
        ovc_free = '1;
        clr(); put(1, 1, 1'b0, 1'b1, 0); step(); expect_grant("R7 tail keeps vc1", 1, 1, 1, 0);

        // R5 with a pointer that favours the speculative input (North).
        clr(); put(1, 0, 1'b1, 1'b0, 2); step(); expect_grant("R5 setup head", 1, 0, 0, 2);
        clr(); put(1, 0, 1'b0, 1'b0, 2); put(0, 1, 1'b1, 1'b0, 2); step();
        expect_grant("R5 body beats head", 1, 0, 0, 2);
        clr(); put(1, 0, 1'b0, 1'b1, 2); put(0, 1, 1'b1, 1'b0, 2); step();
        expect_grant("R5 tail beats head", 1, 0, 0, 2);
        clr(); put(0, 1, 1'b1, 1'b0, 2); step(); expect_grant("R5 waiting head served", 0, 1, 0, 2);
        clr(); put(0, 1, 1'b0, 1'b1, 2); step(); expect_grant("R8 release", 0, 1, 0, 2);

        // R9 input-side selection at input South.
        clr(); put(3, 2, 1'b1, 1'b0, 3); step(); expect_grant("R9 setup", 3, 2, 0, 3);
        clr(); put(3, 0, 1'b1, 1'b0, 0); put(3, 2, 1'b0, 1'b0, 3); step();
        expect_grant("R9 body before head", 3, 2, 0, 3);
        clr(); put(3, 0, 1'b1, 1'b0, 0); put(3, 1, 1'b1, 1'b0, 2); step();
        expect_grant("R9 lowest head", 3, 0, 0, 0);
        clr(); put(3, 0, 1'b0, 1'b1, 0); put(3, 2, 1'b0, 1'b1, 3); step();
        expect_grant("R9 lowest body R10", 3, 0, 0, 0);
        clr(); put(3, 2, 1'b0, 1'b1, 3); step(); expect_grant("R9 remaining tail", 3, 2, 0, 3);
        clr(); put(2, 1, 1'b0, 1'b1, 3); step(); expect_idle("R9 stray body ignored");
        clr(); put(2, 1, 1'b1, 1'b0, 3); step(); expect_grant("R9 no state from stray", 2, 1, 0, 3);
        clr(); put(2, 1, 1'b0, 1'b1, 3); step(); expect_grant("R8 tail", 2, 1, 0, 3);

        // R10: two inputs to two outputs in one cycle.
        clr(); put(0, 0, 1'b1, 1'b1, 4); put(1, 0, 1'b1, 1'b1, 4); put(2, 0, 1'b1, 1'b1, 0); step();
        total++;
        if (!(gv == 5'b00101 && xen == 5'b10001 && xsel[4*PW +: PW] == 3'd0 && xsel[0 +: PW] == 3'd2)) begin
            bad++;
            $display("FAIL R10: gv=%b xen=%b ; expected gv=00101 xen=10001", gv, xen);
        end
        clr(); step(); expect_idle("R2 idle after drop");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule